// File: doc/BRIEF.md
# Three-Channel Interval Timer

This peripheral holds three down-counters that a processor reaches over a small address/data bus with separate read and write strobes. Addresses 0, 1 and 2 select the counters. A write loads a new count and a read returns the current count. Each counter is clocked from its own input. The three can therefore run at one shared rate or at unrelated rates, and each one counts with no dependence on the other two.

The bus logic runs on the processor clock. Each counter runs in its own clock domain. A load value crosses into a counter domain through a toggle handshake. The running count comes back to the bus domain as a coherent snapshot through a two-phase request/acknowledge exchange, so a read never returns a mix of old and new bits. When a counter steps from one to zero it halts and raises a sticky per-channel flag in the bus domain. The interrupt line is the OR of every flag whose channel has its interrupt enabled.

Software sets a per-channel run bit and interrupt-enable bit in the control register. It reads the flags from the status register and clears them by writing ones.

Top module: `interval_timer`

## Requirements
- R1: After reset every counter reads 0, the control and status registers read 0, and `irq` is low.
- R2: A write to address 0, 1 or 2 loads `wr_data` into that counter. After the crossing delay, a read of the same address returns the loaded value, and the other counters keep their values.
- R3: `rd_data` is registered. It returns the addressed register in the cycle after `rd_en` is sampled high. It is 0 in any cycle after an edge where `rd_en` was low. Addresses 5, 6 and 7 read as 0.
- R4: Address 3 is the control register. Bit 2c is the run bit of channel c and bit 2c+1 is its interrupt enable. It reads back as written. Writes to addresses 5 to 7 change no register.
- R5: While its run bit is set and its count is nonzero, a counter falls by exactly one on each rising edge of its own clock. Apart from a load it never changes by any other amount.
- R6: A counter that has reached 0 stays at 0 until it is loaded again.
- R7: Each counter advances only on its own clock and only while its own run bit is set. Channels with different clock periods lose counts in proportion to their rates, and a channel whose run bit is clear keeps its value.
- R8: When a counter steps from 1 to 0, bit c of the status register (address 4) becomes 1. Loading 0 or resting at 0 does not set it.
- R9: A status bit stays set until a write to address 4 carries a 1 in that bit position. Writing 0 there leaves it set. A new zero event takes priority over a clear in the same cycle.
- R10: `irq` is high exactly when some channel has both its status bit and its interrupt enable set. A control or status write shows on `irq` from the cycle after the write.
- R11: A load applied while a counter is running replaces the count. A load takes priority over a decrement on the same counter edge.
- R12: A read of a running counter returns a value the counter actually held. Successive reads never increase and never jump by more than the elapsed counter edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| cnt_clk | input | NUM_CH | One counting clock per channel |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | CNT_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Control and status writes affect `irq` in the bus cycle right after the write edge. Read data is due one bus cycle after the read strobe. The bench samples both at the next falling edge and checks them exactly against a model of the enable and read-strobe history that it updates every cycle. Loads, count progress and zero flags must cross two-flop synchronizers in both directions, which takes a few cycles of the slowest clock. The bench therefore waits a fixed settling interval well beyond that round trip before it reads, and checks counts taken while running against windows computed from the clock periods rather than exact values.

// File: rtl/itm_pkg.sv
package itm_pkg;
    // Control register layout: each channel owns a pair of adjacent bits.
    localparam int unsigned CTL_STRIDE  = 2;
    localparam int unsigned CTL_RUN_OFS = 0;
    localparam int unsigned CTL_IE_OFS  = 1;

    function automatic int unsigned ctl_run_pos(input int unsigned ch);
        return CTL_STRIDE * ch + CTL_RUN_OFS;
    endfunction

    function automatic int unsigned ctl_ie_pos(input int unsigned ch);
        return CTL_STRIDE * ch + CTL_IE_OFS;
    endfunction
endpackage

// File: rtl/itm_sync.sv
module itm_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/itm_cnt_core.sv
module itm_cnt_core #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             cclk,
    input  logic             rst_n,
    input  logic             load_tgl_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             snap_ack_i,
    output logic             snap_req_o,
    output logic [CNT_W-1:0] snap_o,
    output logic             zero_tgl_o,
    output logic [CNT_W-1:0] count_o,
    output logic             load_apply_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             load_seen;
        logic             zero_tgl;
        logic [CNT_W-1:0] snap;
        logic             snap_req;
    } core_st_t;

    core_st_t   st_d, st_q;
    logic [2:0] sync_q;
    logic       load_s, run_s, ack_s, load_apply;

    // Bus-domain controls brought into this counter's clock domain.
    itm_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
        .clk   (cclk),
        .rst_n (rst_n),
        .d     ({load_tgl_i, run_i, snap_ack_i}),
        .q     (sync_q)
    );

    assign load_s = sync_q[2];
    assign run_s  = sync_q[1];
    assign ack_s  = sync_q[0];

    always_comb begin
        st_d           = st_q;
        load_apply     = load_s ^ st_q.load_seen;
        st_d.load_seen = load_s;

        // A load wins over a decrement on the same edge.
        if (load_apply) begin
            st_d.count = load_val_i;
        end else if (run_s && (st_q.count != '0)) begin
            st_d.count = st_q.count - CNT_ONE;
            if (st_q.count == CNT_ONE) st_d.zero_tgl = ~st_q.zero_tgl;
        end

        // Start a new snapshot once the previous one is acknowledged.
        if (ack_s == st_q.snap_req) begin
            st_d.snap     = st_q.count;
            st_d.snap_req = ~st_q.snap_req;
        end
    end

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_req_o   = st_q.snap_req;
    assign snap_o       = st_q.snap;
    assign zero_tgl_o   = st_q.zero_tgl;
    assign count_o      = st_q.count;
    assign load_apply_o = load_apply;
endmodule

// File: rtl/itm_bus_chan.sv
module itm_bus_chan #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             clr_i,
    input  logic             snap_req_i,
    input  logic [CNT_W-1:0] snap_i,
    input  logic             zero_tgl_i,
    output logic             load_tgl_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             snap_ack_o,
    output logic [CNT_W-1:0] mirror_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] load_val;
        logic             load_tgl;
        logic             ack;
        logic [CNT_W-1:0] mirror;
        logic             zero_seen;
        logic             flag;
    } chan_st_t;

    chan_st_t   st_d, st_q;
    logic [1:0] sync_q;
    logic       req_s, zero_s, zero_evt;

    // Counter-domain toggles brought into the bus clock domain.
    itm_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({snap_req_i, zero_tgl_i}),
        .q     (sync_q)
    );

    assign req_s  = sync_q[1];
    assign zero_s = sync_q[0];

    always_comb begin
        st_d = st_q;

        if (wr_load_i) begin
            st_d.load_val = wr_data_i;
            st_d.load_tgl = ~st_q.load_tgl;
        end

        // The snapshot has been stable since its request toggled.
        if (req_s != st_q.ack) begin
            st_d.mirror = snap_i;
            st_d.ack    = req_s;
        end

        zero_evt       = zero_s ^ st_q.zero_seen;
        st_d.zero_seen = zero_s;
        if (zero_evt)   st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_tgl_o = st_q.load_tgl;
    assign load_val_o = st_q.load_val;
    assign snap_ack_o = st_q.ack;
    assign mirror_o   = st_q.mirror;
    assign flag_o     = st_q.flag;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itm_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cnt_clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(NUM_CH + 1);

    typedef struct packed {
        logic [NUM_CH-1:0] run;
        logic [NUM_CH-1:0] ie;
        logic [CNT_W-1:0]  rd_data;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_CH-1:0]            wr_ch, clr_vec, flag_vec, ie_vec;
    logic [NUM_CH-1:0]            load_tgl, snap_ack, snap_req, zero_tgl, load_apply_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] load_val, snap, mirror, count_vec;

    always_comb begin
        st_d         = st_q;
        st_d.rd_data = '0;
        wr_ch        = '0;
        clr_vec      = '0;

        for (int c = 0; c < NUM_CH; c++) begin
            wr_ch[c] = wr_en && (addr == ADDR_W'(c));
        end

        if (wr_en && (addr == ADR_STAT)) clr_vec = wr_data[NUM_CH-1:0];

        if (wr_en && (addr == ADR_CTRL)) begin
            for (int c = 0; c < NUM_CH; c++) begin
                st_d.run[c] = wr_data[ctl_run_pos(c)];
                st_d.ie[c]  = wr_data[ctl_ie_pos(c)];
            end
        end

        if (rd_en) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr == ADDR_W'(c)) st_d.rd_data = mirror[c];
            end
            if (addr == ADR_CTRL) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    st_d.rd_data[ctl_run_pos(c)] = st_q.run[c];
                    st_d.rd_data[ctl_ie_pos(c)]  = st_q.ie[c];
                end
            end
            if (addr == ADR_STAT) st_d.rd_data[NUM_CH-1:0] = flag_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        itm_bus_chan #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_bus (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_load_i  (wr_ch[c]),
            .wr_data_i  (wr_data),
            .clr_i      (clr_vec[c]),
            .snap_req_i (snap_req[c]),
            .snap_i     (snap[c]),
            .zero_tgl_i (zero_tgl[c]),
            .load_tgl_o (load_tgl[c]),
            .load_val_o (load_val[c]),
            .snap_ack_o (snap_ack[c]),
            .mirror_o   (mirror[c]),
            .flag_o     (flag_vec[c])
        );

        itm_cnt_core #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cnt (
            .cclk         (cnt_clk[c]),
            .rst_n        (rst_n),
            .load_tgl_i   (load_tgl[c]),
            .load_val_i   (load_val[c]),
            .run_i        (st_q.run[c]),
            .snap_ack_i   (snap_ack[c]),
            .snap_req_o   (snap_req[c]),
            .snap_o       (snap[c]),
            .zero_tgl_o   (zero_tgl[c]),
            .count_o      (count_vec[c]),
            .load_apply_o (load_apply_vec[c])
        );
    end

    assign ie_vec  = st_q.ie;
    assign rd_data = st_q.rd_data;
    assign irq     = |(flag_vec & st_q.ie);
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            cnt_clk,
    input logic                         rd_en,
    input logic [CNT_W-1:0]             rd_data,
    input logic                         irq,
    input logic [NUM_CH-1:0]            ie_vec,
    input logic [NUM_CH-1:0]            flag_vec,
    input logic [NUM_CH-1:0]            clr_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0] count_vec,
    input logic [NUM_CH-1:0]            load_apply_vec
);
    // R3
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_vec == '0) |-> !irq);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        // R9
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_vec[c] && !clr_vec[c]) |=> flag_vec[c]);

        // R6
        stop_at_zero_chk: assert property (@(posedge cnt_clk[c]) disable iff (!rst_n)
            ((count_vec[c] == '0) && !load_apply_vec[c]) |=> (count_vec[c] == '0));

        // R5
        single_step_chk: assert property (@(posedge cnt_clk[c]) disable iff (!rst_n)
            !load_apply_vec[c] |=> ((count_vec[c] == $past(count_vec[c])) ||
                                    (count_vec[c] == $past(count_vec[c]) - 1'b1)));
    end
endmodule

bind interval_timer interval_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnt_clk        (cnt_clk),
    .rd_en          (rd_en),
    .rd_data        (rd_data),
    .irq            (irq),
    .ie_vec         (ie_vec),
    .flag_vec       (flag_vec),
    .clr_vec        (clr_vec),
    .count_vec      (count_vec),
    .load_apply_vec (load_apply_vec)
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb_top;
    localparam int SETTLE = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cnt_clk = 3'b000;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Behavioural model of the bus-side state that is due cycle-exactly.
    logic [2:0] m_ie = 3'b000;
    logic       m_last_rd = 1'b0;

    always #2.5  clk = ~clk;
    always #3    cnt_clk[0] = ~cnt_clk[0];
    always #5    cnt_clk[1] = ~cnt_clk[1];
    always #12.5 cnt_clk[2] = ~cnt_clk[2];

    interval_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_clk (cnt_clk),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // Per-cycle comparison against the model (R3, R10).
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (!m_last_rd && rd_data != 16'h0) begin
                fails++;
                $display("FAIL R3 idle read data act=%h exp=0000", rd_data);
            end
            if (m_ie == 3'b000 && irq) begin
                fails++;
                $display("FAIL R10 irq with no enable act=1 exp=0");
            end
        end
        m_last_rd = rd_en;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s act=%0d exp=[%0d..%0d]", req, act, lo, hi);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 3'd3) m_ie = {d[5], d[3], d[1]};
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            tests++;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v, prev;
        #51.3 rst_n = 1'b1;
        idle(4);

        // R1 reset state
        for (int c = 0; c < 5; c++) begin
            bus_rd(3'(c), v);
            check("R1 reset register", v, 16'h0);
        end
        check("R1 reset irq", {15'h0, irq}, 16'h0);

        // R2 loads with counting stopped
        bus_wr(3'd0, 16'd100);
        bus_wr(3'd1, 16'd200);
        bus_wr(3'd2, 16'd300);
        idle(SETTLE);
        bus_rd(3'd0, v); check("R2 load ch0", v, 16'd100);
        bus_rd(3'd1, v); check("R2 load ch1", v, 16'd200);
        bus_rd(3'd2, v); check("R2 load ch2", v, 16'd300);

        // R4 control read back, irq quiet without flags
        bus_wr(3'd3, 16'h002A);
        bus_rd(3'd3, v); check("R4 control readback", v, 16'h002A);
        check("R10 no flag no irq", {15'h0, irq}, 16'h0);

        // R4 / R3 unmapped addresses
        bus_wr(3'd5, 16'hFFFF);
        bus_wr(3'd7, 16'hFFFF);
        idle(SETTLE);
        bus_rd(3'd3, v); check("R4 unmapped write ignored ctrl", v, 16'h002A);
        bus_rd(3'd4, v); check("R4 unmapped write ignored stat", v, 16'h0);
        bus_rd(3'd1, v); check("R4 unmapped write ignored ch1", v, 16'd200);
        bus_rd(3'd5, v); check("R3 unmapped read", v, 16'h0);
        bus_rd(3'd7, v); check("R3 unmapped read", v, 16'h0);

        // R5 / R7 different rates over a 1005 ns run window
        bus_wr(3'd3, 16'h003E);
        idle(200);
        bus_wr(3'd3, 16'h002A);
        idle(SETTLE);
        bus_rd(3'd1, v); check_rng("R7 ch1 10ns rate", int'(v), 96, 103);
        bus_rd(3'd2, v); check_rng("R7 ch2 25ns rate", int'(v), 257, 263);
        bus_rd(3'd0, v); check("R7 stopped ch0 unchanged", v, 16'd100);
        idle(SETTLE);
        bus_rd(3'd1, prev); bus_rd(3'd1, v);
        check("R7 run clear freezes ch1", v, prev);

        // R11 load while running, then R12 coherent reads across 0x100
        bus_wr(3'd3, 16'h002B);
        bus_wr(3'd0, 16'h0140);
        idle(SETTLE);
        bus_rd(3'd0, prev);
        check_rng("R11 load while running", int'(prev), 240, 310);
        for (int i = 0; i < 30; i++) begin
            bus_rd(3'd0, v);
            check_rng("R12 coherent read step", int'(prev) - int'(v), 0, 12);
            prev = v;
        end

        // R6 / R8 / R10 reaching zero
        idle(400);
        bus_rd(3'd0, v); check("R6 stops at zero", v, 16'h0);
        bus_rd(3'd4, v); check("R8 zero sets flag", v, 16'h0001);
        check("R10 irq raised", {15'h0, irq}, 16'h0001);
        idle(SETTLE);
        bus_rd(3'd0, v); check("R6 remains zero", v, 16'h0);

        // R9 writing zero keeps flag; R10 mask and unmask
        bus_wr(3'd4, 16'h0000);
        bus_rd(3'd4, v); check("R9 zero write keeps flag", v, 16'h0001);
        bus_wr(3'd3, 16'h0029);
        check("R10 irq masked", {15'h0, irq}, 16'h0);
        bus_rd(3'd4, v); check("R10 flag kept while masked", v, 16'h0001);
        bus_wr(3'd3, 16'h002B);
        check("R10 irq unmasked", {15'h0, irq}, 16'h0001);
        bus_wr(3'd4, 16'h0001);
        check("R9 clear drops irq", {15'h0, irq}, 16'h0);
        bus_rd(3'd4, v); check("R9 clear flag", v, 16'h0);

        // R8 loading zero while running raises no flag
        bus_wr(3'd0, 16'h0000);
        idle(SETTLE);
        bus_rd(3'd4, v); check("R8 load zero no flag", v, 16'h0);

        // R11 reload after zero, short count to zero again
        bus_wr(3'd0, 16'd1000);
        idle(SETTLE);
        bus_rd(3'd0, v); check_rng("R11 reload running", int'(v), 900, 999);
        bus_wr(3'd0, 16'd5);
        idle(SETTLE);
        bus_rd(3'd0, v); check("R6 short count ends at zero", v, 16'h0);
        bus_rd(3'd4, v); check("R8 short count flag", v, 16'h0001);
        bus_wr(3'd4, 16'h0007);
        bus_rd(3'd4, v); check("R9 clear all", v, 16'h0);

        finish_run();
    end
endmodule